// File: doc/BRIEF.md
# High-Speed Serial Receive Path with Idle Timeout

This block is the receive half of a fast serial port with a fixed 8N1 frame: 8 data bits, least significant first, no parity and one stop bit. It watches an oversampled line (16 sample ticks per bit, with the ticks supplied by an external rate generator) and rebuilds each character. It then queues the character in a 64-deep first-in first-out store. Every character is tagged with a framing-error flag and a break flag. When the store is empty, a read returns a word with a dedicated empty bit, so software can drain the store until that bit appears.

The block raises two interrupt requests. The first is a fill-level request, active for as long as the number of stored characters is at or above a selectable threshold. The second is an idle-timeout request. It fires when characters have been waiting, with no new arrival and no read, for a selectable number of character times. The block also gives one-cycle event pulses for framing errors, breaks and overruns. Those pulses feed interrupt latches that sit outside this block.

Top module: `hsu_rx_path`

## Requirements
- R1: While the store holds data, `rd_word_o` shows the oldest character. The data byte is in bits 7:0, bit 8 is 0, bit 9 is the framing-error flag and bit 10 is the break flag. A pulse on `rd_i` removes that character, and characters come out in arrival order.
- R2: While the store is empty, `rd_word_o` equals 0x100 (only bit 8 set), and a read does not change the fill level.
- R3: `level_o` reports the number of stored characters (0 to 64). It changes on the clock edge that ends a push or a read cycle.
- R4: `trig_irq_o` is high exactly while the fill level is at or above the threshold chosen by `trig_sel_i`. Codes 0 to 5 select 1, 4, 8, 16, 32 and 48. Codes 6 and 7 also select 48.
- R5: A character that completes while 64 characters are stored is discarded. It raises `ovr_evt_o` for one cycle, and the level stays at 64.
- R6: A character whose stop bit samples low and whose data byte is not zero is stored with bit 9 set, and it pulses `fe_evt_o` once.
- R7: A character whose data bits and stop bit all sample low is stored as 0x400 and pulses `brk_evt_o` once. The receiver does not look for a new start bit until the line has returned high, so a held-low line yields one break only.
- R8: `tmo_irq_o` rises after the idle counter reaches its limit. The counter advances only on sample ticks and only while the store is not empty. `tmo_sel_i` code 0 disables it. Codes 1, 2 and 3 select 4, 8 and 16 character times, where one character time is 10 bits of 16 ticks each.
- R9: The idle counter starts again on every stored or overrun character and on every read, so `tmo_irq_o` is low in the cycle after either event.
- R10: A start bit is confirmed at its middle, 8 ticks after the falling edge is seen. A low pulse shorter than that produces no character. Data and stop bits are each sampled 16 ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversample enable, 16 per bit time |
| rd_i | input | 1 | Read strobe, one cycle per character |
| trig_sel_i | input | 3 | Fill-level threshold code |
| tmo_sel_i | input | 2 | Idle-timeout length code |
| rd_word_o | output | 11 | Head character with status tags |
| level_o | output | 8 | Number of stored characters |
| trig_irq_o | output | 1 | Fill-level request |
| tmo_irq_o | output | 1 | Idle-timeout request |
| fe_evt_o | output | 1 | Framing-error pulse |
| brk_evt_o | output | 1 | Break pulse |
| ovr_evt_o | output | 1 | Overrun pulse |

## Verification
A character reaches the store two sync flops plus one output register after the middle of its stop bit, which is about half a bit before the line is released. The bench therefore checks level, word and event counts only after one full idle bit has followed each frame. A read updates `level_o` on the very next edge, and `rd_word_o` and `trig_irq_o` follow the level combinationally. The bench samples them at falling edges, and for the threshold sweep it samples one time step after changing the threshold code. The timeout is due about `limit - 24` ticks after the bench's idle bit ends. It is checked low 40 ticks before the limit and high at the limit, so the sync and sampling latency falls inside that window. After a read it is checked 8 ticks either side of the limit.

// File: rtl/hsu_rx_pkg.sv
package hsu_rx_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = 11;
  localparam int BITS_PER_CHAR = 10;

  typedef struct packed {
    logic             brk;
    logic             fe;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  function automatic int trig_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int idle_chars(input logic [1:0] sel);
    case (sel)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/hsu_rx_deser.sv
module hsu_rx_deser
  import hsu_rx_pkg::*;
#(
  parameter int OVS   = 16,
  localparam int CW   = $clog2(OVS),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rxd_i,
  input  logic     tick_i,
  output logic     vld_o,
  output rx_char_t chr_o
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} st_e;

  st_e              st_q;
  logic [1:0]       sync_q;
  logic [CW-1:0]    cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [DATA_W-1:0] shr_q;
  logic             rxd_s;

  assign rxd_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      shr_q  <= '0;
      vld_o  <= 1'b0;
      chr_o  <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      vld_o  <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          S_IDLE: if (!rxd_s) begin
            st_q  <= S_START;
            cnt_q <= '0;
          end
          S_START: begin
            if (cnt_q == CW'(OVS/2 - 1)) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= rxd_s ? S_IDLE : S_DATA;   // glitch rejected at mid start
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_DATA: begin
            if (cnt_q == CW'(OVS - 1)) begin
              cnt_q <= '0;
              shr_q <= {rxd_s, shr_q[DATA_W-1:1]};
              if (bit_q == BIT_W'(DATA_W - 1)) st_q <= S_STOP;
              else bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_STOP: begin
            if (cnt_q == CW'(OVS - 1)) begin
              cnt_q      <= '0;
              vld_o      <= 1'b1;
              chr_o.data <= shr_q;
              chr_o.brk  <= !rxd_s && (shr_q == '0);
              chr_o.fe   <= !rxd_s && (shr_q != '0);
              st_q       <= rxd_s ? S_IDLE : S_HOLD;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_HOLD: if (rxd_s) st_q <= S_IDLE;     // re-arm only once line is high
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hsu_rx_fifo.sv
module hsu_rx_fifo
  import hsu_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  rx_char_t      din_i,
  input  logic          rd_i,
  output rx_char_t      dout_o,
  output logic [NW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  rx_char_t      mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          push, pop;

  assign full_o  = (count_o == NW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign push    = wr_i && !full_o;
  assign pop     = rd_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      count_o <= count_o + NW'(push) - NW'(pop);
    end
  end
endmodule

// File: rtl/hsu_rx_idle_timer.sv
module hsu_rx_idle_timer
  import hsu_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int MAX_CHARS = 16,
  localparam int CHAR_TICKS = OVS * BITS_PER_CHAR,
  localparam int CW         = $clog2(MAX_CHARS * CHAR_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic       armed_i,
  input  logic [1:0] sel_i,
  output logic       expired_o
);
  logic [CW-1:0] cnt_q, lim;

  assign lim       = CW'(idle_chars(sel_i) * CHAR_TICKS);
  assign expired_o = (sel_i != 2'd0) && armed_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart_i || !armed_i || sel_i == 2'd0) cnt_q <= '0;
    else if (tick_i && cnt_q != lim) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hsu_rx_path.sv
module hsu_rx_path
  import hsu_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 64,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic [2:0]        trig_sel_i,
  input  logic [1:0]        tmo_sel_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [7:0]        level_o,
  output logic              trig_irq_o,
  output logic              tmo_irq_o,
  output logic              fe_evt_o,
  output logic              brk_evt_o,
  output logic              ovr_evt_o
);
  logic          char_vld;
  rx_char_t      char_d, head;
  logic [NW-1:0] count;
  logic          full, empty;

  hsu_rx_deser #(.OVS(OVS)) u_deser (
    .clk_i, .rst_ni, .rxd_i, .tick_i,
    .vld_o (char_vld),
    .chr_o (char_d)
  );

  hsu_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i    (char_vld),
    .din_i   (char_d),
    .rd_i    (rd_i),
    .dout_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  hsu_rx_idle_timer #(.OVS(OVS)) u_tmo (
    .clk_i, .rst_ni, .tick_i,
    .restart_i (char_vld || rd_i),
    .armed_i   (!empty),
    .sel_i     (tmo_sel_i),
    .expired_o (tmo_irq_o)
  );

  assign rd_word_o  = empty ? WORD_W'(9'h100) : {head.brk, head.fe, 1'b0, head.data};
  assign level_o    = 8'(count);
  assign trig_irq_o = (int'(count) >= trig_level(trig_sel_i));
  assign fe_evt_o   = char_vld && char_d.fe;
  assign brk_evt_o  = char_vld && char_d.brk;
  assign ovr_evt_o  = char_vld && full;
endmodule

// File: rtl/hsu_rx_path_chk.sv
module hsu_rx_path_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic        push_i,
  input logic [2:0]  trig_sel_i,
  input logic [10:0] rd_word_o,
  input logic [7:0]  level_o,
  input logic        trig_irq_o,
  input logic        tmo_irq_o,
  input logic        fe_evt_o,
  input logic        brk_evt_o,
  input logic        ovr_evt_o
);
  // R3
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= DEPTH);
  // R3
  level_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && level_o != 8'd0 && !push_i) |=> level_o == 8'($past(level_o) - 8'd1));
  // R2
  empty_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 8'd0) |-> rd_word_o == 11'h100);
  // R5
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt_o |-> int'(level_o) == DEPTH);
  // R5
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_evt_o && !rd_i) |=> int'(level_o) == DEPTH);
  // R7
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fe_evt_o, brk_evt_o}));
  // R8
  tmo_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_irq_o |-> level_o != 8'd0);
  // R9
  tmo_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || rd_i) |=> !tmo_irq_o);
  // R4
  trig_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 3'd0) |-> trig_irq_o == (level_o != 8'd0));
endmodule

bind hsu_rx_path hsu_rx_path_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .push_i     (char_vld),
  .trig_sel_i (trig_sel_i),
  .rd_word_o  (rd_word_o),
  .level_o    (level_o),
  .trig_irq_o (trig_irq_o),
  .tmo_irq_o  (tmo_irq_o),
  .fe_evt_o   (fe_evt_o),
  .brk_evt_o  (brk_evt_o),
  .ovr_evt_o  (ovr_evt_o)
);

// File: tb/hsu_rx_path_bench.sv
module hsu_rx_path_bench;
  localparam int OVS = 16;
  localparam int DEPTH = 64;
  localparam int CHAR_TICKS = OVS * 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, rxd_i = 1'b1, tick_i = 1'b0, rd_i = 1'b0;
  logic [2:0]  trig_sel_i = 3'd0;
  logic [1:0]  tmo_sel_i = 2'd0;
  logic [10:0] rd_word_o;
  logic [7:0]  level_o;
  logic        trig_irq_o, tmo_irq_o, fe_evt_o, brk_evt_o, ovr_evt_o;

  int n_cmp = 0, n_err = 0, n_fe = 0, n_brk = 0, n_ovr = 0;
  logic [10:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  hsu_rx_path u_hsu_rx_path (.*);

  initial forever @(negedge clk_i) tick_i = ~tick_i;
  initial forever @(negedge clk_i) if (rst_ni) begin
    if (fe_evt_o)  n_fe++;
    if (brk_evt_o) n_brk++;
    if (ovr_evt_o) n_ovr++;
  end

  function automatic int exp_thr(int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; 3: return 16; 4: return 32; default: return 48; endcase
  endfunction
  function automatic int exp_lim(int s);
    return (s == 0) ? 0 : (4 << (s - 1)) * CHAR_TICKS;
  endfunction
  function automatic logic [10:0] exp_word(logic [7:0] d, logic stop);
    if (stop) return {3'b000, d};
    if (d == 8'h00) return 11'h400;
    return {3'b010, d};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_bits(int n);
    repeat (n * 2 * OVS) @(negedge clk_i);
  endtask

  task automatic send_char(logic [7:0] d, logic stop, int extra_low = 0);
    rxd_i = 1'b0; wait_bits(1);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; wait_bits(1); end
    rxd_i = stop; wait_bits(1 + extra_low);
    rxd_i = 1'b1;
    if (exp_q.size() < DEPTH) exp_q.push_back(exp_word(d, stop));
    wait_bits(1);
  endtask

  task automatic rd_chk(string tag);
    logic [10:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 11'h100;
    chk(tag, rd_word_o, e);
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic drain(string tag);
    while (exp_q.size() != 0) rd_chk(tag);
    chk({tag, " level"}, level_o, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int b0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk("R3 reset level", level_o, 0);
    chk("R2 reset word", rd_word_o, 11'h100);
    chk("R8 reset tmo", tmo_irq_o, 0);
    chk("R4 reset trig", trig_irq_o, 0);

    // R1 ordering with random bytes
    for (int k = 1; k <= 5; k++) begin
      send_char(8'($urandom_range(1, 255)), 1'b1);
      chk("R3 level after push", level_o, k);
    end
    drain("R1 word");
    rd_chk("R2 empty read");
    @(negedge clk_i);
    chk("R2 level after empty read", level_o, 0);

    // R10 short glitch ignored
    rxd_i = 1'b0; repeat (8) @(negedge clk_i); rxd_i = 1'b1;
    wait_bits(12);
    chk("R10 glitch no char", level_o, 0);

    // R4 threshold sweep while filling, then R5 overrun
    for (int k = 1; k <= DEPTH; k++) begin
      send_char(8'($urandom()), 1'b1);
      for (int s = 0; s < 8; s++) begin
        trig_sel_i = 3'(s); #1;
        chk($sformatf("R4 trig sel%0d lvl%0d", s, k), trig_irq_o, int'(k >= exp_thr(s)));
      end
    end
    trig_sel_i = 3'd0;
    b0 = n_ovr;
    send_char(8'h5a, 1'b1);
    chk("R5 overrun pulse", n_ovr - b0, 1);
    chk("R5 level held", level_o, DEPTH);
    drain("R5 word after overrun");

    // R6 framing error, R7 break with held-low line
    b0 = n_fe;
    send_char(8'ha5, 1'b0);
    chk("R6 fe pulse", n_fe - b0, 1);
    b0 = n_brk;
    send_char(8'h00, 1'b0, 3);
    chk("R7 single break", n_brk - b0, 1);
    chk("R7 level", level_o, 2);
    drain("R6 R7 word");

    // R8 timeout lengths
    for (int s = 1; s <= 3; s++) begin
      tmo_sel_i = 2'(s);
      send_char(8'h3c, 1'b1);
      repeat (2 * (exp_lim(s) - 40)) @(negedge clk_i);
      chk($sformatf("R8 tmo early sel%0d", s), tmo_irq_o, 0);
      repeat (2 * 40) @(negedge clk_i);
      chk($sformatf("R8 tmo due sel%0d", s), tmo_irq_o, 1);
      drain("R8 word");
      chk("R8 tmo clears empty", tmo_irq_o, 0);
    end
    tmo_sel_i = 2'd0;
    send_char(8'h77, 1'b1);
    repeat (2 * (exp_lim(1) + 100)) @(negedge clk_i);
    chk("R8 tmo disabled", tmo_irq_o, 0);
    drain("R8 word");

    // R9 read restarts the idle count
    tmo_sel_i = 2'd1;
    send_char(8'h11, 1'b1);
    send_char(8'h22, 1'b1);
    repeat (2 * exp_lim(1)) @(negedge clk_i);
    chk("R9 tmo before read", tmo_irq_o, 1);
    rd_chk("R9 word");
    chk("R9 tmo after read", tmo_irq_o, 0);
    repeat (2 * (exp_lim(1) - 8)) @(negedge clk_i);
    chk("R9 tmo early after read", tmo_irq_o, 0);
    repeat (2 * 16) @(negedge clk_i);
    chk("R9 tmo due after read", tmo_irq_o, 1);
    drain("R9 word");
    tmo_sel_i = 2'd0;

    // random mix of arrivals and reads
    b0 = n_fe + n_brk;
    for (int it = 0; it < 24; it++) begin
      if ($urandom_range(0, 2) != 0 || exp_q.size() == 0) begin
        logic [7:0] d;
        d = ($urandom_range(0, 5) == 0) ? 8'h00 : 8'($urandom());
        send_char(d, ($urandom_range(0, 3) != 0));
      end else rd_chk("R1 random word");
      chk("R3 random level", level_o, exp_q.size());
    end
    drain("R1 random drain");

    finish_run();
  end
endmodule